// File: doc/BRIEF.md
# SCSI Controller Register Bank and Command Decoder

This block is the host-visible register bank of a SCSI protocol controller. A byte-wide bus reaches sixteen register slots. The slot number is the bus address shifted right by a parameter, which lets the bank sit on word-aligned addresses. Several slots have one meaning when read and another when written. Every write is kept in a write-side copy. Only some slots also update the value that a read returns.

A byte written to the command slot is decoded. Its top bit picks DMA mode and loads the readable transfer count from the written count bytes. The low seven bits pick an operation. That operation updates the read-only status, interrupt-cause, sequence-step and FIFO-flag registers. A single level interrupt output follows the pending bit (bit 7) of the status register. Software clears the interrupt by reading the interrupt-cause register. Bus signalling, attached targets and the memory-side DMA engine live elsewhere.

Top module: `scsi_regblock`

## Requirements
- R1: The slot is `bus_addr >> ADDR_SHIFT`. A read strobe returns the readable copy of that slot on `bus_rdata` one clock later.
- R2: After reset every readable slot is 0x00, except config1 (slot 8), which is 0x07, and count-high (slot 14), which is the identity value 0x04. `irq` is low.
- R3: Writes to slots 4, 5, 6, 7, 9 and 10 leave every readable value unchanged.
- R4: Writes to slots 8 and 11 to 15 are read back unchanged.
- R5: A command byte with bit 7 set copies the last written count-low (slot 0) and count-mid (slot 1) bytes into their readable copies. With bit 7 clear, the readable counts do not change. Writing slot 0 or 1 alone never changes the readable counts.
- R6: Command 0x01 (flush) sets the interrupt cause (slot 5) to 0x08 and clears sequence (slot 6) and FIFO flags (slot 7).
- R7: Command 0x03 (bus reset) sets the interrupt cause to 0x80. It raises the interrupt only when config1 bit 6 is clear.
- R8: Reading the interrupt cause (slot 5) clears status (slot 4) bits 7, 6 and 5, which drops `irq`.
- R9: Writing slot 0 or slot 1 clears status bit 4 (terminal count).
- R10: Command 0x02 (chip reset) returns the bank to the R2 state and clears DMA mode.
- R11: Command 0x44 (enable selection) clears the interrupt cause.
- R12: Command 0x11 (initiator complete) sets the interrupt cause to 0x08, sets status bits 2:0 to 7 and raises the interrupt. In DMA mode the status becomes 0x97 and sequence becomes 0x04. Otherwise the FIFO flags become 0x02.
- R13: Command 0x12 (message accepted) sets the interrupt cause to 0x20, clears sequence and raises the interrupt. In DMA mode the status becomes 0x93. Otherwise the FIFO flags become 0x02.
- R14: `irq` equals status bit 7 at every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address; the slot is the address shifted right by ADDR_SHIFT |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| irq | output | 1 | Level interrupt, equal to status bit 7 |

## Verification
A write takes effect at the clock edge that samples the strobe. Its effects on the registers and on `irq` are therefore visible from that edge on. Read data is registered, so it shows the slot's value from before the read's own side effect and is valid after the same edge. The bench drives every strobe for exactly one cycle. It samples `irq` and `bus_rdata` on the next falling edge, after the model has applied the same operation. The interrupt-cause clear thus shows up in the following status read and never in the read that caused it.

// File: rtl/scsi_reg_pkg.sv
package scsi_reg_pkg;
    localparam int BYTE_W    = 8;
    localparam int NUM_SLOTS = 16;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);

    // slot numbers whose position software relies on
    localparam logic [SLOT_W-1:0] SL_CNT_LO  = 4'd0;
    localparam logic [SLOT_W-1:0] SL_CNT_MID = 4'd1;
    localparam logic [SLOT_W-1:0] SL_CMD     = 4'd3;
    localparam logic [SLOT_W-1:0] SL_STAT    = 4'd4;
    localparam logic [SLOT_W-1:0] SL_INTR    = 4'd5;
    localparam logic [SLOT_W-1:0] SL_SEQ     = 4'd6;
    localparam logic [SLOT_W-1:0] SL_FLAGS   = 4'd7;
    localparam logic [SLOT_W-1:0] SL_CFG1    = 4'd8;
    localparam logic [SLOT_W-1:0] SL_CNT_HI  = 4'd14;

    // slots whose write lands only in the write-side copy
    localparam logic [NUM_SLOTS-1:0] WO_MASK = 16'b0000_0110_1111_0000;
    // slots where a write also updates the readable copy
    localparam logic [NUM_SLOTS-1:0] RW_MASK = 16'b1111_1001_0000_0000;

    // operation codes (command bits 6:0)
    localparam logic [6:0] OP_FLUSH   = 7'h01;
    localparam logic [6:0] OP_CHIPRST = 7'h02;
    localparam logic [6:0] OP_BUSRST  = 7'h03;
    localparam logic [6:0] OP_INIT_CC = 7'h11;
    localparam logic [6:0] OP_MSG_OK  = 7'h12;
    localparam logic [6:0] OP_SEL_EN  = 7'h44;

    // register values
    localparam logic [BYTE_W-1:0] ST_PEND   = 8'h80;
    localparam logic [BYTE_W-1:0] ST_ERRS   = 8'h60;
    localparam logic [BYTE_W-1:0] ST_TC     = 8'h10;
    localparam logic [BYTE_W-1:0] ST_PHASE  = 8'h07;
    localparam logic [BYTE_W-1:0] ST_TC_STS = 8'h13;
    localparam logic [BYTE_W-1:0] IC_FDONE  = 8'h08;
    localparam logic [BYTE_W-1:0] IC_BSVC   = 8'h10;
    localparam logic [BYTE_W-1:0] IC_DISC   = 8'h20;
    localparam logic [BYTE_W-1:0] IC_BRST   = 8'h80;
    localparam logic [BYTE_W-1:0] SQ_CDONE  = 8'h04;
    localparam logic [BYTE_W-1:0] CFG1_INIT = 8'h07;
    localparam logic [BYTE_W-1:0] ID_VALUE  = 8'h04;

    typedef logic [NUM_SLOTS-1:0][BYTE_W-1:0] bank_t;

    typedef struct packed {
        bank_t              rd;
        bank_t              sh;
        logic               dma;
        logic [BYTE_W-1:0]  rdata;
    } regs_t;

    typedef struct packed {
        logic [BYTE_W-1:0] stat;
        logic [BYTE_W-1:0] intr;
        logic [BYTE_W-1:0] seq;
        logic [BYTE_W-1:0] flags;
        logic              chip_reset;
    } upd_t;
endpackage

// File: rtl/scsi_slot_decode.sv
module scsi_slot_decode
    import scsi_reg_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int ADDR_SHIFT = 2
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [SLOT_W-1:0]    slot,
    output logic [NUM_SLOTS-1:0] sel,
    output logic                 wo_hit,
    output logic                 rw_hit
);
    localparam logic [ADDR_W-1:0] SHIFTED_UNUSED = '0;

    always_comb begin
        slot = SLOT_W'((addr | SHIFTED_UNUSED) >> ADDR_SHIFT);
    end

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_sel
        assign sel[i] = (slot == SLOT_W'(i));
    end

    assign wo_hit = |(sel & WO_MASK);
    assign rw_hit = |(sel & RW_MASK);
endmodule

// File: rtl/scsi_cmd_exec.sv
module scsi_cmd_exec
    import scsi_reg_pkg::*;
(
    input  logic [BYTE_W-1:0] cmd_i,
    input  logic [BYTE_W-1:0] stat_i,
    input  logic [BYTE_W-1:0] intr_i,
    input  logic [BYTE_W-1:0] seq_i,
    input  logic [BYTE_W-1:0] flags_i,
    input  logic              brst_mask_i,
    output upd_t              upd_o
);
    logic       dma_mode;
    logic [6:0] op;

    assign dma_mode = cmd_i[7];
    assign op       = cmd_i[6:0];

    always_comb begin
        upd_o.stat       = stat_i;
        upd_o.intr       = intr_i;
        upd_o.seq        = seq_i;
        upd_o.flags      = flags_i;
        upd_o.chip_reset = 1'b0;
        case (op)
            OP_FLUSH: begin
                upd_o.intr  = IC_FDONE;
                upd_o.seq   = '0;
                upd_o.flags = '0;
            end
            OP_CHIPRST: upd_o.chip_reset = 1'b1;
            OP_BUSRST: begin
                upd_o.intr = IC_BRST;
                if (!brst_mask_i) upd_o.stat = stat_i | ST_PEND;
            end
            OP_INIT_CC, OP_MSG_OK: begin
                // status-phase response
                if (dma_mode) begin
                    upd_o.stat = ST_TC_STS | ST_PEND;
                    upd_o.intr = IC_BSVC | IC_FDONE;
                    upd_o.seq  = SQ_CDONE;
                end else begin
                    upd_o.flags = 8'h02;
                    upd_o.stat  = stat_i | ST_PEND;
                end
                if (op == OP_INIT_CC) begin
                    upd_o.intr = IC_FDONE;
                    upd_o.stat = upd_o.stat | ST_PHASE;
                end else begin
                    upd_o.intr = IC_DISC;
                    upd_o.seq  = '0;
                end
            end
            OP_SEL_EN: upd_o.intr = '0;
            default: ;
        endcase
    end
endmodule

// File: rtl/scsi_regblock.sv
module scsi_regblock
    import scsi_reg_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int ADDR_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq
);
    function automatic regs_t reset_val();
        regs_t r;
        r               = '0;
        r.rd[SL_CFG1]   = CFG1_INIT;
        r.rd[SL_CNT_HI] = ID_VALUE;
        return r;
    endfunction

    regs_t                 regs_d, regs_q;
    upd_t                  upd;
    logic [SLOT_W-1:0]     slot;
    logic [NUM_SLOTS-1:0]  sel;
    logic                  wo_hit, rw_hit;

    scsi_slot_decode #(.ADDR_W(ADDR_W), .ADDR_SHIFT(ADDR_SHIFT)) i_dec (
        .addr   (bus_addr),
        .slot   (slot),
        .sel    (sel),
        .wo_hit (wo_hit),
        .rw_hit (rw_hit)
    );

    scsi_cmd_exec i_exec (
        .cmd_i       (bus_wdata),
        .stat_i      (regs_q.rd[SL_STAT]),
        .intr_i      (regs_q.rd[SL_INTR]),
        .seq_i       (regs_q.rd[SL_SEQ]),
        .flags_i     (regs_q.rd[SL_FLAGS]),
        .brst_mask_i (regs_q.rd[SL_CFG1][6]),
        .upd_o       (upd)
    );

    always_comb begin
        regs_d = regs_q;
        if (bus_rd) begin
            regs_d.rdata = regs_q.rd[slot];
            if (sel[SL_INTR]) regs_d.rd[SL_STAT] = regs_q.rd[SL_STAT] & ~(ST_PEND | ST_ERRS);
        end
        if (bus_wr) begin
            regs_d.sh[slot] = bus_wdata;
            if (sel[SL_CNT_LO] || sel[SL_CNT_MID]) begin
                regs_d.rd[SL_STAT] = regs_d.rd[SL_STAT] & ~ST_TC;
            end else if (sel[SL_CMD]) begin
                regs_d.rd[SL_CMD] = bus_wdata;
                regs_d.dma        = bus_wdata[7];
                if (bus_wdata[7]) begin
                    regs_d.rd[SL_CNT_LO]  = regs_q.sh[SL_CNT_LO];
                    regs_d.rd[SL_CNT_MID] = regs_q.sh[SL_CNT_MID];
                end
                regs_d.rd[SL_STAT]  = upd.stat;
                regs_d.rd[SL_INTR]  = upd.intr;
                regs_d.rd[SL_SEQ]   = upd.seq;
                regs_d.rd[SL_FLAGS] = upd.flags;
                if (upd.chip_reset) begin
                    regs_d            = reset_val();
                    regs_d.sh[SL_CMD] = bus_wdata;
                    regs_d.rdata      = bus_rd ? regs_q.rd[slot] : regs_q.rdata;
                end
            end else if (rw_hit) begin
                regs_d.rd[slot] = bus_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= reset_val();
        else        regs_q <= regs_d;
    end

    assign bus_rdata = regs_q.rdata;
    assign irq       = regs_q.rd[SL_STAT][7];

    // R8
    intr_read_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && slot == SL_INTR) |=> !irq);

    // R7
    bus_reset_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd && slot == SL_CMD && bus_wdata[6:0] == OP_BUSRST
         && regs_q.rd[SL_CFG1][6] && !irq) |=> !irq);

    // R10
    chip_reset_ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && slot == SL_CMD && bus_wdata[6:0] == OP_CHIPRST)
        |=> (regs_q.rd[SL_CNT_HI] == ID_VALUE && regs_q.rd[SL_CFG1] == CFG1_INIT && !irq));

    // R9
    count_write_clears_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (slot == SL_CNT_LO || slot == SL_CNT_MID)) |=> !regs_q.rd[SL_STAT][4]);

    // R3
    write_only_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd && wo_hit) |=> $stable(regs_q.rd));
endmodule

// File: tb/test_scsi_regblock.sv
`timescale 1ns/1ps
module test_scsi_regblock;
    localparam int AW = 6;
    localparam int SH = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [7:0] m_rd [16];
    logic [7:0] m_sh [16];
    bit         m_dma;

    always #2.5 clk = ~clk;

    scsi_regblock #(.ADDR_W(AW), .ADDR_SHIFT(SH)) i_scsi_regblock (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic void m_reset();
        for (int i = 0; i < 16; i++) begin m_rd[i] = 8'h00; m_sh[i] = 8'h00; end
        m_rd[8]  = 8'h07;
        m_rd[14] = 8'h04;
        m_dma    = 0;
    endfunction

    function automatic void m_write(int s, logic [7:0] d);
        m_sh[s] = d;
        if (s <= 1) begin
            m_rd[4] = m_rd[4] & 8'hEF;
        end else if (s == 3) begin
            m_rd[3] = d;
            m_dma   = d[7];
            if (d[7]) begin m_rd[0] = m_sh[0]; m_rd[1] = m_sh[1]; end
            case (d[6:0])
                7'h01: begin m_rd[5] = 8'h08; m_rd[6] = 0; m_rd[7] = 0; end
                7'h02: begin m_reset(); m_sh[3] = d; end
                7'h03: begin m_rd[5] = 8'h80; if (!m_rd[8][6]) m_rd[4] = m_rd[4] | 8'h80; end
                7'h11: begin
                    if (d[7]) begin m_rd[4] = 8'h97; m_rd[6] = 8'h04; end
                    else begin m_rd[4] = m_rd[4] | 8'h87; m_rd[7] = 8'h02; end
                    m_rd[5] = 8'h08;
                end
                7'h12: begin
                    if (d[7]) m_rd[4] = 8'h93;
                    else begin m_rd[4] = m_rd[4] | 8'h80; m_rd[7] = 8'h02; end
                    m_rd[5] = 8'h20; m_rd[6] = 8'h00;
                end
                7'h44: m_rd[5] = 8'h00;
                default: ;
            endcase
        end else if (s == 8 || s >= 11) begin
            m_rd[s] = d;
        end
    endfunction

    function automatic logic [7:0] m_read(int s);
        logic [7:0] v = m_rd[s];
        if (s == 5) m_rd[4] = m_rd[4] & 8'h1F;
        return v;
    endfunction

    task automatic chk(logic [7:0] act, logic [7:0] exp, string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(int s, logic [7:0] d, string req);
        @(negedge clk);
        bus_addr = AW'(s << SH); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        m_write(s, d);
        chk({7'd0, irq}, {7'd0, m_rd[4][7]}, req);
    endtask

    task automatic rd(int s, string req);
        logic [7:0] e;
        @(negedge clk);
        bus_addr = AW'(s << SH); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        e = m_read(s);
        chk(bus_rdata, e, req);
        chk({7'd0, irq}, {7'd0, m_rd[4][7]}, "R14");
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [6:0] ops [10];
        ops = '{7'h00, 7'h01, 7'h03, 7'h10, 7'h11, 7'h12, 7'h1A, 7'h42, 7'h43, 7'h44};
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2 reset state
        chk({7'd0, irq}, 8'h00, "R2");
        for (int s = 0; s < 16; s++) rd(s, "R2");
        // R4 readable config slots
        wr(11, 8'h5A, "R4"); rd(11, "R4");
        wr(15, 8'hC3, "R4"); rd(15, "R4");
        // R7 masked and unmasked bus reset
        wr(8, 8'h47, "R4"); rd(8, "R4");
        wr(3, 8'h03, "R7"); chk({7'd0, irq}, 8'h00, "R7"); rd(5, "R7");
        wr(8, 8'h07, "R7");
        wr(3, 8'h03, "R7"); chk({7'd0, irq}, 8'h01, "R7");
        rd(4, "R14");
        // R8 interrupt-cause read clears pending
        rd(5, "R8"); chk({7'd0, irq}, 8'h00, "R8"); rd(4, "R8");
        // R5 counter reload
        wr(0, 8'h34, "R5"); wr(1, 8'h12, "R5");
        rd(0, "R5"); wr(3, 8'h00, "R5"); rd(0, "R5"); rd(1, "R5");
        wr(3, 8'h80, "R5"); rd(0, "R5"); rd(1, "R5");
        // R12 DMA initiator complete, then R9
        wr(3, 8'h91, "R12"); chk({7'd0, irq}, 8'h01, "R12");
        rd(4, "R12"); rd(6, "R12");
        wr(0, 8'h01, "R9"); rd(4, "R9");
        rd(5, "R12"); rd(4, "R8");
        // R12 non-DMA
        wr(3, 8'h11, "R12"); rd(7, "R12"); rd(4, "R12"); rd(5, "R12");
        // R13 message accepted, both modes
        wr(3, 8'h12, "R13"); rd(7, "R13"); rd(6, "R13"); rd(5, "R13");
        wr(3, 8'h92, "R13"); rd(4, "R13"); rd(5, "R13");
        // R6 flush
        wr(3, 8'h01, "R6"); rd(5, "R6"); rd(6, "R6"); rd(7, "R6");
        // R11 enable selection
        wr(3, 8'h44, "R11"); rd(5, "R11");
        // R3 write-only slots
        wr(3, 8'h03, "R3");
        foreach (ops[k]) if (k < 6) wr((k < 4) ? 4 + k : 5 + k, 8'hFF, "R3");
        for (int s = 4; s < 11; s++) rd(s, "R3");
        // R10 chip reset
        wr(12, 8'h77, "R10"); wr(3, 8'h82, "R10");
        chk({7'd0, irq}, 8'h00, "R10");
        for (int s = 0; s < 16; s++) rd(s, "R10");
        // R1 random traffic
        void'($urandom(32'd4242));
        for (int n = 0; n < 1500; n++) begin
            int s = $urandom % 16;
            if ($urandom % 2) begin
                logic [7:0] d = 8'($urandom);
                if (s == 3) d = {d[7], (($urandom % 40) == 0) ? 7'h02 : ops[$urandom % 10]};
                wr(s, d, "R1");
            end else begin
                rd(s, "R1");
            end
        end
        summary();
    end
endmodule